// File: doc/BRIEF.md
# Shift-Mask-Merge Bitwise Unit

This unit is a three-source bitwise operator for an integer datapath. A single 4-bit operation code chooses one of five fused operations. Four of them shift source B by the amount held in source A, then either keep only the bits that source C allows (mask) or set the bits that source C carries (merge). The fifth operation ANDs sources A and B and then ORs in source C. The result is treated as an unsigned integer.

A precision flag selects how wide the operands are. In full precision all 32 bits take part. In half precision only the low 16 bits of every source are used, and the result is 16 bits wide, zero-extended to 32. The shift amount takes 5 bits in full precision and 4 bits in half precision, so a shift always stays inside the operand width.

Each operation is accepted together with `in_valid`. Its result, and a flag that marks an unknown operation code, are registered and appear one clock later with `out_valid`. The registered outputs hold their values until the next valid input.

Top module: `shmerge_alu`

## Requirements
- R1: Operation code 4'b1000 yields (B >> A) & C.
- R2: Operation code 4'b1001 yields (B << A) & C.
- R3: Operation code 4'b1010 yields (B >> A) | C.
- R4: Operation code 4'b1011 yields (B << A) | C.
- R5: Operation code 4'b1100 yields (B & A) | C.
- R6: Right shifts are logical. Vacated high bits of the operand width fill with zero, even when the top bit of B is set.
- R7: The shift amount is the low 5 bits of A in full precision (in_half=0) and the low 4 bits of A in half precision (in_half=1). Higher bits of A have no effect on shift results.
- R8: In half precision, bits 31:16 of every source are ignored and bits 31:16 of the result are zero. Bits shifted left past bit 15 are lost.
- R9: Any operation code other than 4'b1000 through 4'b1100 gives a result of zero with out_illegal=1. A legal code gives out_illegal=0.
- R10: out_valid is in_valid delayed by one clock. The result and out_illegal for an accepted input appear in that same cycle.
- R11: After reset, out_valid, out_result and out_illegal are all zero.
- R12: While in_valid is low, out_result and out_illegal keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operation is valid this cycle |
| in_op | input | 4 | Operation code |
| in_half | input | 1 | 1 = 16-bit half precision, 0 = 32-bit full precision |
| in_a | input | 32 | Source A: shift amount, or AND operand for 4'b1100 |
| in_b | input | 32 | Source B: value to be shifted |
| in_c | input | 32 | Source C: mask or merge operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 32 | Registered result |
| out_illegal | output | 1 | Registered unknown-operation flag |

## Verification
The bench drives right shifts of values whose top bit is set. A design that shifted arithmetically would fill the upper bits with ones instead of zeros.

It uses shift amounts of 16 and above in half precision, and 32 and above in full precision. A design that used too many bits of A would shift everything out, while one that used too few would drop shift steps. It also loads junk into the upper halves of the sources in half precision and shifts left across bit 15, which shows whether any upper bits leak into the result.

Codes just below and just above the legal range, plus idle gaps between operations, test that an unknown code clears the result and raises the flag, and that idle cycles leave the outputs unchanged.

// File: rtl/shmerge_alu.sv
module shmerge_alu #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic              in_half,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [DATA_W-1:0] in_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  localparam int SH_FULL = $clog2(DATA_W);
  localparam int SH_HALF = $clog2(HALF_W);
  localparam logic [3:0] OP_SHR_MASK  = 4'b1000;
  localparam logic [3:0] OP_SHL_MASK  = 4'b1001;
  localparam logic [3:0] OP_SHR_MERGE = 4'b1010;
  localparam logic [3:0] OP_SHL_MERGE = 4'b1011;
  localparam logic [3:0] OP_AND_MERGE = 4'b1100;
  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [DATA_W-1:0]  width_mask;
  logic [DATA_W-1:0]  a_m, b_m, c_m;
  logic [SH_FULL-1:0] amt;
  logic [DATA_W-1:0]  shr, shl, raw, res_d;
  logic               bad_op;

  assign width_mask = in_half ? HALF_MASK : '1;
  assign a_m = in_a & width_mask;
  assign b_m = in_b & width_mask;
  assign c_m = in_c & width_mask;
  assign amt = in_half ? {{(SH_FULL-SH_HALF){1'b0}}, in_a[SH_HALF-1:0]} : in_a[SH_FULL-1:0];
  assign shr = b_m >> amt;
  assign shl = b_m << amt;

  always_comb begin
    bad_op = 1'b0;
    unique case (in_op)
      OP_SHR_MASK:  raw = shr & c_m;
      OP_SHL_MASK:  raw = shl & c_m;
      OP_SHR_MERGE: raw = shr | c_m;
      OP_SHL_MERGE: raw = shl | c_m;
      OP_AND_MERGE: raw = (b_m & a_m) | c_m;
      default: begin
        raw    = '0;
        bad_op = 1'b1;
      end
    endcase
  end

  assign res_d = raw & width_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_d;
        out_illegal <= bad_op;
      end
    end
  end
endmodule

module shmerge_alu_chk #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [3:0]        in_op,
  input logic              in_half,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [DATA_W-1:0] in_c,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op < 4'b1000 || in_op > 4'b1100)) |=> (out_illegal && out_result == '0));
  assert_legal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= 4'b1000 && in_op <= 4'b1100) |=> !out_illegal);
  assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_half) |=> (out_result[DATA_W-1:HALF_W] == '0));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_illegal)));
endmodule

bind shmerge_alu shmerge_alu_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/shmerge_alu_tb.sv
module shmerge_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_op = '0;
  logic        in_half = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_illegal;

  int total = 0;
  int bad = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic [32:0] last_exp = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  shmerge_alu u_dut (.*);

  function automatic logic [32:0] model(input logic [3:0] op, input logic half,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    logic [31:0] m, aa, bb, cc, r;
    int s;
    m  = half ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    aa = a & m; bb = b & m; cc = c & m;
    s  = half ? int'(a[3:0]) : int'(a[4:0]);
    case (op)
      4'b1000: r = (bb >> s) & cc;
      4'b1001: r = (bb << s) & cc;
      4'b1010: r = (bb >> s) | cc;
      4'b1011: r = (bb << s) | cc;
      4'b1100: r = (bb & aa) | cc;
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, r & m};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [3:0] op, input logic half,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_half = half; in_a = a; in_b = b; in_c = c;
    exp_q.push_back(model(op, half, a, b, c));
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 4'b1001; in_a = 32'h3; in_b = 32'hFFFF_FFFF; in_c = 32'hFFFF_FFFF;
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R10 unexpected out_valid", 33'd1, 33'd0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(t, {out_illegal, out_result}, e);
        end
      end
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {out_valid, out_illegal, out_result}, 34'h0);
    rst_n = 1'b1;
    @(negedge clk);

    drive("R1 shr-mask full",   4'b1000, 1'b0, 32'd4,  32'hF0F0_1234, 32'h0FFF_FF0F);
    drive("R2 shl-mask full",   4'b1001, 1'b0, 32'd8,  32'h00AB_CDEF, 32'hFFF0_0FFF);
    drive("R3 shr-merge full",  4'b1010, 1'b0, 32'd12, 32'h1234_5678, 32'h8000_0001);
    drive("R4 shl-merge full",  4'b1011, 1'b0, 32'd31, 32'h0000_0003, 32'h0000_0010);
    drive("R5 and-merge full",  4'b1100, 1'b0, 32'hFF00_FF00, 32'h1234_5678, 32'h0000_000F);
    drive("R6 logical shr full", 4'b1010, 1'b0, 32'd31, 32'h8000_0000, 32'h0);
    drive("R6 logical shr half", 4'b1000, 1'b1, 32'd3,  32'h0000_8000, 32'hFFFF_FFFF);
    drive("R7 full amt 32 wraps", 4'b1011, 1'b0, 32'd32, 32'hDEAD_BEEF, 32'h0);
    drive("R7 full amt 0x25",     4'b1010, 1'b0, 32'h25, 32'h8000_0000, 32'h0);
    drive("R7 half amt 16 wraps", 4'b1011, 1'b1, 32'd16, 32'h0000_1234, 32'h0);
    drive("R7 half amt 0x1F",     4'b1000, 1'b1, 32'h1F, 32'h0000_FFFF, 32'hFFFF_FFFF);
    drive("R8 half junk upper",   4'b1100, 1'b1, 32'hFFFF_00F0, 32'hABCD_0FF0, 32'h5555_0001);
    drive("R8 half shl overflow", 4'b1001, 1'b1, 32'd8, 32'h0000_ABCD, 32'hFFFF_FFFF);
    drive("R9 illegal 0111",      4'b0111, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive("R9 legal after",       4'b1010, 1'b0, 32'd1, 32'h2, 32'h0);
    drive("R9 illegal 1101",      4'b1101, 1'b1, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    drive("R9 illegal 0000",      4'b0000, 1'b0, 32'd0, 32'h1, 32'h1);
    drive("R9 illegal 1111",      4'b1111, 1'b0, 32'd0, 32'h1, 32'h1);
    drive("R1 back to back",      4'b1000, 1'b0, 32'd1, 32'hFFFF_FFFF, 32'h0F0F_0F0F);
    idle(1);
    @(negedge clk);
    check("R10 out_valid low after idle", {31'b0, out_valid}, 32'h0);
    idle(3);
    @(negedge clk);
    check("R12 hold while idle", {out_illegal, out_result}, last_exp);

    drive("R9 illegal before idle", 4'b0101, 1'b0, 32'd0, 32'h7, 32'h7);
    idle(4);
    @(negedge clk);
    check("R12 hold illegal while idle", {out_illegal, out_result}, 33'h1_0000_0000);

    for (int k = 0; k < 300; k++) begin
      logic [3:0] op;
      op = (k % 7 == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(8, 12));
      drive("R1-5 random mix", op, 1'($urandom), $urandom, $urandom, $urandom);
      if (k % 37 == 0) idle(2);
    end
    idle(3);
    @(negedge clk);
    check("R10 queue drained", 33'(exp_q.size()), 33'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule